// File: doc/BRIEF.md
# Idle Mode Power Controller

This block governs the light-sleep state of a small 8-bit controller core. Software writes a one-register power control port. Setting the low bit of that register arms idle mode. The CPU clock enable is then withdrawn once the core reports that its current instruction has completed. While the CPU is frozen, the peripheral clock enable stays on, so the timers, the serial port, the I/O and the watchdog keep running.

Idle ends in one of two ways. An interrupt request whose enable bit is set returns the core to the run state and emits a one-cycle wake strobe, so interrupt service begins from the saved return point. A reset from the external pin or from the watchdog clears the idle bit and drives a fixed 24-clock internal reset, which is two machine cycles of 12 clocks each. No oscillator startup wait is applied to these resets, because the oscillator was never stopped. Only a cold power-on applies a parameterised startup delay before that same 24-clock pulse.

Top module: `idle_pwr_ctl`

## Requirements
- R1: While `por_i` is high, `rst_o` is 1 and both clock enables are 0. After `por_i` falls, `rst_o` stays high for STARTUP_CLKS + 24 further clocks (88 with defaults) and then drops, with `cpu_clk_en_o` high.
- R2: A write with `wr_en_i` high sets the idle bit to `wr_data_i[0]`. The bit reads back on `rd_data_o[0]`, and `rd_data_o[7:1]` are always 0.
- R3: After the idle bit is set, `cpu_clk_en_o` stays 1 until the clock in which `instr_end_i` is high, and it is 0 from the next clock on. If the write and `instr_end_i` fall in the same clock, idle begins on the next clock.
- R4: While idle, `cpu_clk_en_o` is 0 and `per_clk_en_o` is 1.
- R5: While idle, a request with `irq_req_i[k]` and `irq_en_i[k]` both 1 for some k causes the following on the next clock: `cpu_clk_en_o` is 1, the idle bit reads 0, and `wake_o` is 1 for exactly one clock.
- R6: While idle, requests whose enable bit is 0 do not wake the block. The idle bit stays 1, `cpu_clk_en_o` stays 0 and `wake_o` stays 0.
- R7: A one-clock pulse on `ext_rst_i` or `wdt_rst_i`, taken from the run or idle state, clears the idle bit. It also holds `rst_o` high for exactly 24 clocks, starting with the next clock, with no startup delay. `cpu_clk_en_o` is 1 during that reset.
- R8: If a reset request and an enabled interrupt arrive in the same idle clock, the reset wins: `rst_o` rises, `wake_o` stays 0 and the idle bit is cleared.
- R9: Writes made while idle (CPU clock off) are ignored, and the idle bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Cold power-on flag, active high |
| ext_rst_i | input | 1 | External reset request |
| wdt_rst_i | input | 1 | Watchdog reset request |
| wr_en_i | input | 1 | Power control register write strobe |
| wr_data_i | input | 8 | Write data; bit 0 is the idle request |
| instr_end_i | input | 1 | Final machine cycle of the current instruction ends |
| irq_req_i | input | NUM_IRQ | Interrupt request lines |
| irq_en_i | input | NUM_IRQ | Interrupt enable bits |
| rd_data_o | output | 8 | Power control register read value |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| rst_o | output | 1 | Internal reset |
| wake_o | output | 1 | One-clock strobe on interrupt exit from idle |

## Verification
Two exits from idle can be requested in the same clock: an enabled interrupt and a watchdog reset. The bench parks the block in idle and raises an enabled request on one line in the same clock as a one-clock watchdog pulse. It then expects `rst_o` to rise on the next clock, `wake_o` to stay low for the whole 24-clock reset, and the idle bit to read 0 afterwards. The same reset path is also driven alone from idle and from run, so the 24-clock length can be compared across all three cases.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned IDLE_BIT = 0;

    typedef enum logic [2:0] {
        PS_COLD  = 3'd0,
        PS_RESET = 3'd1,
        PS_RUN   = 3'd2,
        PS_PEND  = 3'd3,
        PS_IDLE  = 3'd4
    } pwr_state_e;

endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
    parameter int unsigned NUM_IRQ = 5
) (
    input  logic [NUM_IRQ-1:0] req_i,
    input  logic [NUM_IRQ-1:0] en_i,
    output logic               hit_o
);
    logic [NUM_IRQ-1:0] armed;

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
        assign armed[k] = req_i[k] & en_i[k];
    end

    assign hit_o = |armed;
endmodule

// File: rtl/idle_rst_merge.sv
module idle_rst_merge #(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] src_i,
    output logic               any_o
);
    assign any_o = |src_i;
endmodule

// File: rtl/idle_pwr_ctl.sv
module idle_pwr_ctl
    import idle_pwr_pkg::*;
#(
    parameter int unsigned NUM_IRQ      = 5,
    parameter int unsigned MC_CLKS      = 12,
    parameter int unsigned RST_MCYC     = 2,
    parameter int unsigned STARTUP_CLKS = 64
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               ext_rst_i,
    input  logic               wdt_rst_i,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic               instr_end_i,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               cpu_clk_en_o,
    output logic               per_clk_en_o,
    output logic               rst_o,
    output logic               wake_o
);
    localparam int unsigned RST_CLKS = MC_CLKS * RST_MCYC;
    localparam int unsigned MAX_CNT  = (STARTUP_CLKS > RST_CLKS) ? STARTUP_CLKS : RST_CLKS;
    localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CLKS - 1);
    localparam logic [CNT_W-1:0] COLD_LAST = CNT_W'(STARTUP_CLKS - 1);

    typedef struct packed {
        pwr_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             idle;
        logic             wake;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wake_hit;
    logic rst_req;
    logic new_idle;

    idle_wake_detect #(.NUM_IRQ(NUM_IRQ)) wake_i (
        .req_i (irq_req_i),
        .en_i  (irq_en_i),
        .hit_o (wake_hit)
    );

    idle_rst_merge #(.NUM_SRC(2)) rmerge_i (
        .src_i ({wdt_rst_i, ext_rst_i}),
        .any_o (rst_req)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.wake = 1'b0;
        new_idle   = wr_en_i ? wr_data_i[IDLE_BIT] : ctl_q.idle;
        if (por_i) begin
            ctl_d.state = PS_COLD;
            ctl_d.cnt   = '0;
            ctl_d.idle  = 1'b0;
        end else if (ctl_q.state == PS_COLD) begin
            if (ctl_q.cnt == COLD_LAST) begin
                ctl_d.state = PS_RESET;
                ctl_d.cnt   = '0;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end else if (rst_req) begin
            ctl_d.state = PS_RESET;
            ctl_d.cnt   = '0;
            ctl_d.idle  = 1'b0;
        end else begin
            case (ctl_q.state)
                PS_RESET: begin
                    if (ctl_q.cnt == RST_LAST) begin
                        ctl_d.state = PS_RUN;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                PS_RUN, PS_PEND: begin
                    ctl_d.idle = new_idle;
                    if (new_idle) begin
                        ctl_d.state = instr_end_i ? PS_IDLE : PS_PEND;
                    end else begin
                        ctl_d.state = PS_RUN;
                    end
                end
                PS_IDLE: begin
                    if (wake_hit) begin
                        ctl_d.state = PS_RUN;
                        ctl_d.idle  = 1'b0;
                        ctl_d.wake  = 1'b1;
                    end
                end
                default: begin
                    ctl_d.state = PS_RESET;
                    ctl_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data_o           = '0;
        rd_data_o[IDLE_BIT] = ctl_q.idle;
    end

    assign rst_o        = (ctl_q.state == PS_COLD) || (ctl_q.state == PS_RESET);
    assign cpu_clk_en_o = (ctl_q.state == PS_RUN) || (ctl_q.state == PS_PEND)
                       || (ctl_q.state == PS_RESET);
    assign per_clk_en_o = (ctl_q.state != PS_COLD);
    assign wake_o       = ctl_q.wake;

endmodule

// File: rtl/idle_pwr_chk.sv
module idle_pwr_chk #(
    parameter int unsigned NUM_IRQ = 5
) (
    input logic               clk,
    input logic               por_i,
    input logic               ext_rst_i,
    input logic               wdt_rst_i,
    input logic               instr_end_i,
    input logic [NUM_IRQ-1:0] irq_req_i,
    input logic [NUM_IRQ-1:0] irq_en_i,
    input logic [7:0]         rd_data_o,
    input logic               cpu_clk_en_o,
    input logic               per_clk_en_o,
    input logic               rst_o,
    input logic               wake_o
);
    logic quiet;
    assign quiet = ((irq_req_i & irq_en_i) == '0) && !ext_rst_i && !wdt_rst_i;

    // R4
    idle_per_on_chk: assert property (@(posedge clk) disable iff (por_i)
        (!cpu_clk_en_o && !rst_o) |-> per_clk_en_o);

    // R5
    wake_single_chk: assert property (@(posedge clk) disable iff (por_i)
        wake_o |=> !wake_o);

    // R5
    wake_run_chk: assert property (@(posedge clk) disable iff (por_i)
        wake_o |-> (cpu_clk_en_o && !rd_data_o[0]));

    // R8
    rst_no_wake_chk: assert property (@(posedge clk) disable iff (por_i)
        rst_o |-> !wake_o);

    // R7
    rst_clears_chk: assert property (@(posedge clk) disable iff (por_i)
        rst_o |-> !rd_data_o[0]);

    // R3
    drop_at_end_chk: assert property (@(posedge clk) disable iff (por_i)
        ($fell(cpu_clk_en_o) && !rst_o) |-> $past(instr_end_i));

    // R6
    masked_stay_chk: assert property (@(posedge clk) disable iff (por_i)
        (!cpu_clk_en_o && !rst_o && quiet) |=> !cpu_clk_en_o);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (por_i)
        rd_data_o[7:1] == 7'd0);
endmodule

bind idle_pwr_ctl idle_pwr_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
    .clk          (clk),
    .por_i        (por_i),
    .ext_rst_i    (ext_rst_i),
    .wdt_rst_i    (wdt_rst_i),
    .instr_end_i  (instr_end_i),
    .irq_req_i    (irq_req_i),
    .irq_en_i     (irq_en_i),
    .rd_data_o    (rd_data_o),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .rst_o        (rst_o),
    .wake_o       (wake_o)
);

// File: tb/idle_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module idle_pwr_ctl_tb_top;
    localparam int NIRQ = 5;
    localparam int COLD = 64;
    localparam int RSTN = 24;

    logic            clk = 1'b0;
    logic            por_i = 1'b1;
    logic            ext_rst_i = 1'b0;
    logic            wdt_rst_i = 1'b0;
    logic            wr_en_i = 1'b0;
    logic [7:0]      wr_data_i = '0;
    logic            instr_end_i = 1'b0;
    logic [NIRQ-1:0] irq_req_i = '0;
    logic [NIRQ-1:0] irq_en_i = '0;
    logic [7:0]      rd_data_o;
    logic            cpu_clk_en_o, per_clk_en_o, rst_o, wake_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    idle_pwr_ctl #(.NUM_IRQ(NIRQ), .STARTUP_CLKS(COLD)) dut_i (
        .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .wdt_rst_i(wdt_rst_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .instr_end_i(instr_end_i),
        .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .rd_data_o(rd_data_o),
        .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
        .rst_o(rst_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_rst(output int n);
        n = 0;
        while (rst_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_cold();
        int n;
        repeat (3) @(negedge clk);
        check("R1 rst during por", rst_o, 1);
        check("R1 cpu en during por", cpu_clk_en_o, 0);
        check("R1 per en during por", per_clk_en_o, 0);
        por_i = 1'b0;
        count_rst(n);
        check("R1 cold reset length", n, COLD + RSTN);
        check("R1 cpu en after cold", cpu_clk_en_o, 1);
        check("R2 idle bit after cold", rd_data_o, 0);
    endtask

    task automatic t_enter_idle();
        wr_en_i = 1'b1; wr_data_i = 8'hFF;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
        check("R2 idle bit reads 1, upper 0", rd_data_o, 1);
        check("R3 cpu en held while pending", cpu_clk_en_o, 1);
        repeat (3) @(negedge clk);
        check("R3 cpu en held until instr end", cpu_clk_en_o, 1);
        instr_end_i = 1'b1;
        @(negedge clk);
        instr_end_i = 1'b0;
        check("R3 cpu en off after instr end", cpu_clk_en_o, 0);
        check("R4 per en on in idle", per_clk_en_o, 1);
    endtask

    task automatic t_masked();
        irq_req_i = 5'b00101; irq_en_i = 5'b11010;
        repeat (5) @(negedge clk);
        check("R6 masked keeps cpu off", cpu_clk_en_o, 0);
        check("R6 masked keeps idle bit", rd_data_o[0], 1);
        check("R6 masked no wake", wake_o, 0);
        irq_req_i = '0; irq_en_i = '0;
    endtask

    task automatic t_idle_write();
        wr_en_i = 1'b1; wr_data_i = 8'h00;
        @(negedge clk);
        wr_en_i = 1'b0;
        @(negedge clk);
        check("R9 write in idle ignored", rd_data_o[0], 1);
        check("R9 cpu stays off", cpu_clk_en_o, 0);
    endtask

    task automatic t_wake();
        irq_req_i = 5'b01000; irq_en_i = 5'b01000;
        @(negedge clk);
        irq_req_i = '0; irq_en_i = '0;
        check("R5 cpu en on wake", cpu_clk_en_o, 1);
        check("R5 wake strobe", wake_o, 1);
        check("R5 idle bit cleared", rd_data_o[0], 0);
        @(negedge clk);
        check("R5 wake strobe one clock", wake_o, 0);
    endtask

    task automatic t_same_cycle();
        wr_en_i = 1'b1; wr_data_i = 8'h01; instr_end_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; instr_end_i = 1'b0;
        check("R3 same clock write and end", cpu_clk_en_o, 0);
        check("R4 per en same clock idle", per_clk_en_o, 1);
    endtask

    task automatic t_reset_pulse(input bit use_wdt, input string tag);
        int n;
        if (use_wdt) wdt_rst_i = 1'b1; else ext_rst_i = 1'b1;
        @(negedge clk);
        wdt_rst_i = 1'b0; ext_rst_i = 1'b0;
        check({"R7 cpu en in reset ", tag}, cpu_clk_en_o, 1);
        check({"R7 idle bit cleared ", tag}, rd_data_o[0], 0);
        count_rst(n);
        check({"R7 reset length ", tag}, n, RSTN);
        check({"R7 run after reset ", tag}, cpu_clk_en_o, 1);
    endtask

    task automatic t_collide();
        int n;
        int wakes;
        irq_req_i = 5'b00001; irq_en_i = 5'b00001; wdt_rst_i = 1'b1;
        @(negedge clk);
        irq_req_i = '0; irq_en_i = '0; wdt_rst_i = 1'b0;
        check("R8 reset wins", rst_o, 1);
        check("R8 idle bit cleared", rd_data_o[0], 0);
        n = 0; wakes = 0;
        while (rst_o && n < 1000) begin
            if (wake_o) wakes++;
            n++;
            @(negedge clk);
        end
        check("R8 no wake strobe", wakes, 0);
        check("R8 reset length", n, RSTN);
        check("R8 wake after reset", wake_o, 0);
    endtask

    initial begin
        t_cold();
        t_enter_idle();
        t_masked();
        t_idle_write();
        t_wake();
        t_reset_pulse(1'b0, "ext from run");
        t_same_cycle();
        t_reset_pulse(1'b1, "wdt from idle");
        t_enter_idle();
        t_collide();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1-scope run hung actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule